// File: doc/BRIEF.md
# DMA Transfer Request Register Front End

This block is the software-facing side of a single-channel DMA engine. Software fills a set of staging registers with a transfer description: memory addresses on both sides, row strides, row length and row count (each count held as value minus one) and a repeat flag. It then writes the start register, and the staged description is copied into a small hardware queue under a transfer ID that the block assigns. IDs rotate: each accepted submission takes the current ID, and the counter then moves on by one and wraps.

The datapath is outside the block. The head of the queue is offered on a valid/ready request port together with its ID. The datapath reports each finished transfer with a one-cycle done strobe that carries the ID. Completion appears in a bitmap with one bit per ID. Two interrupt sources are kept in a write-one-to-clear pending register behind a mask, and together they drive a single interrupt line. The request port follows these back-pressure rules. `req_valid` is high only while the queue holds an entry and the channel is enabled and not paused. While `req_valid` is high and `req_ready` is low, the ID and all payload fields stay fixed. A transfer is handed off on a cycle where both are high.

Register access uses a 32-bit synchronous bus with byte addresses. A write takes effect at the clock edge where `bus_wr` is sampled. Read data appears on `bus_rdata` one cycle after `bus_rd`, and holds its value between reads. Offsets not listed below read as zero.

Top module: `dma_req_regs`

## Requirements
- R1: After reset the interrupt mask (0x080) reads 3, the pending register (0x084) reads 0, control (0x400) reads 0, the next-ID register (0x404) reads 0, the completion bitmap (0x428) reads 0, `irq` is low and `req_valid` is low.
- R2: These staging registers read back what was last written, truncated to their width. Destination address 0x410, source address 0x414, destination stride 0x420 and source stride 0x424 are 32 bits. Row length minus one (0x418) and row count minus one (0x41C) are 24 bits. The repeat flag is bit 0 of 0x40C. The interrupt mask is bits 1:0 of 0x080.
- R3: Control bit 0 enables the channel. While it is enabled and the queue is not full, writing the start register (0x408) with bit 0 set queues the staged description. The value read from 0x404 then advances by one, modulo 4.
- R4: Reading 0x408 returns 1 while the queue holds 4 entries or the channel is disabled, and 0 otherwise. A start write made while full or disabled is ignored: the ID does not advance and no extra request appears.
- R5: Queued descriptions are offered on the request port in submission order. Each one carries the fields that were staged at its submission and the ID it was given. While `req_ready` is low, the ID and payload are held.
- R6: While control bit 1 (pause) is set, `req_valid` is low, and queued entries are kept for when the pause is cleared.
- R7: Writing 0 to control discards every queued entry. After the channel is enabled again, `req_valid` stays low until a new submission.
- R8: A done strobe sets the bitmap bit at index `done_id`. Assigning an ID to a new submission clears that ID's bit.
- R9: Pending bit 0 (start-of-transfer, queue space available) is set when a non-repeating entry is handed off. Pending bit 1 (end-of-transfer) is set by each done strobe.
- R10: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R11: `irq` is high exactly when some pending bit has a mask bit of 0. Register 0x088 reads pending AND NOT mask.
- R12: An entry with the repeat flag set stays at the head after each handoff and is offered again with the same ID. Its handoffs do not set pending bit 0. It leaves only when the channel is disabled.
- R13: Register 0x42C reads the ID of the most recent handoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | BUS_AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| req_valid | output | 1 | Request to the datapath is offered |
| req_ready | input | 1 | Datapath takes the request |
| req_id | output | ID_W | ID of the offered transfer |
| req_dst_addr | output | 32 | Destination start address |
| req_src_addr | output | 32 | Source start address |
| req_dst_stride | output | 32 | Destination row stride |
| req_src_stride | output | 32 | Source row stride |
| req_x_len_m1 | output | 24 | Row length minus one |
| req_y_len_m1 | output | 24 | Row count minus one |
| req_cyclic | output | 1 | Repeat flag of the offered transfer |
| done_valid | input | 1 | Transfer-finished strobe |
| done_id | input | ID_W | ID of the finished transfer |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume two things about the datapath. It raises `done_valid` only for an ID it was handed earlier. It never reports a finish for an ID in the same cycle that the ID is handed to a new submission. They also assume the bus does not read and write in one cycle. The bench keeps within these limits: it issues done strobes only for IDs that have already completed a handshake, it strobes only while no submission is in flight, and its bus tasks perform one access at a time. Inside those limits, the bench sweeps whole queue fill and drain rounds, every mask value and every transfer ID.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int DMA_AW = 32;
  localparam int LEN_W  = 24;

  // byte offsets decoded by software
  localparam int OFS_IRQ_MASK = 'h080;
  localparam int OFS_IRQ_PEND = 'h084;
  localparam int OFS_IRQ_SRC  = 'h088;
  localparam int OFS_CTRL     = 'h400;
  localparam int OFS_NEXT_ID  = 'h404;
  localparam int OFS_START    = 'h408;
  localparam int OFS_FLAGS    = 'h40C;
  localparam int OFS_DST      = 'h410;
  localparam int OFS_SRC      = 'h414;
  localparam int OFS_XLEN     = 'h418;
  localparam int OFS_YLEN     = 'h41C;
  localparam int OFS_DSTRIDE  = 'h420;
  localparam int OFS_SSTRIDE  = 'h424;
  localparam int OFS_DONE_MAP = 'h428;
  localparam int OFS_ACT_ID   = 'h42C;

  typedef struct packed {
    logic [DMA_AW-1:0] dst_addr;
    logic [DMA_AW-1:0] src_addr;
    logic [DMA_AW-1:0] dst_stride;
    logic [DMA_AW-1:0] src_stride;
    logic [LEN_W-1:0]  x_len_m1;
    logic [LEN_W-1:0]  y_len_m1;
    logic              cyclic;
  } xfer_desc_t;
endpackage

// File: rtl/dreq_queue.sv
module dreq_queue import dma_req_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     hold,
  input  logic                     push,
  input  xfer_desc_t               push_desc,
  input  logic [ID_W-1:0]          push_id,
  output logic                     out_valid,
  input  logic                     out_ready,
  output xfer_desc_t               out_desc,
  output logic [ID_W-1:0]          out_id,
  output logic                     full,
  output logic                     fired,
  output logic                     popped,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  xfer_desc_t        mem [DEPTH];
  logic [ID_W-1:0]   ids [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign out_valid = (count != '0) && !hold;
  assign out_desc  = mem[rd_ptr];
  assign out_id    = ids[rd_ptr];
  assign full      = (count == CNT_W'(DEPTH));
  assign fired     = out_valid && out_ready;
  // a repeating head is re-offered instead of removed
  assign popped    = fired && !out_desc.cyclic;
  assign level     = count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_desc;
        ids[wr_ptr] <= push_id;
        wr_ptr      <= bump(wr_ptr);
      end
      if (popped) rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(popped);
    end
  end
endmodule

// File: rtl/dreq_done_map.sv
module dreq_done_map #(
  parameter int ID_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_en,
  input  logic [ID_W-1:0]      clr_id,
  input  logic                 set_en,
  input  logic [ID_W-1:0]      set_id,
  output logic [(1<<ID_W)-1:0] done_map
);
  localparam int NUM_IDS = 1 << ID_W;
  logic [NUM_IDS-1:0] nxt;

  always_comb begin
    nxt = done_map;
    if (clr_en) nxt[clr_id] = 1'b0;
    if (set_en) nxt[set_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done_map <= '0;
    else        done_map <= nxt;
  end
endmodule

// File: rtl/dreq_irq.sv
module dreq_irq #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_vec,
  input  logic             mask_we,
  input  logic             pend_we,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] pending,
  output logic [N_SRC-1:0] mask,
  output logic             irq
);
  logic [N_SRC-1:0] clr;
  assign clr = pend_we ? wdata : '0;
  assign irq = |(pending & ~mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      mask    <= '1;
    end else begin
      pending <= (pending & ~clr) | set_vec;
      if (mask_we) mask <= wdata;
    end
  end
endmodule

// File: rtl/dma_req_regs.sv
module dma_req_regs import dma_req_pkg::*; #(
  parameter int BUS_AW = 12,
  parameter int QDEPTH = 4,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ID_W-1:0]   req_id,
  output logic [DMA_AW-1:0] req_dst_addr,
  output logic [DMA_AW-1:0] req_src_addr,
  output logic [DMA_AW-1:0] req_dst_stride,
  output logic [DMA_AW-1:0] req_src_stride,
  output logic [LEN_W-1:0]  req_x_len_m1,
  output logic [LEN_W-1:0]  req_y_len_m1,
  output logic              req_cyclic,
  input  logic              done_valid,
  input  logic [ID_W-1:0]   done_id,
  output logic              irq
);
  localparam int NUM_IDS = 1 << ID_W;
  localparam int CNT_W   = $clog2(QDEPTH + 1);

  logic              ctrl_en, ctrl_pause;
  xfer_desc_t        stage, head;
  logic [ID_W-1:0]   next_id, act_id;
  logic              accept, q_full, q_fired, q_popped;
  logic [CNT_W-1:0]  q_level;
  logic [NUM_IDS-1:0] done_map;
  logic [1:0]        irq_pend, irq_mask;
  logic [31:0]       rd_mux;

  function automatic logic at(input int ofs);
    return bus_addr == BUS_AW'(ofs);
  endfunction

  assign accept = bus_wr && at(OFS_START) && bus_wdata[0] && ctrl_en && !q_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      ctrl_pause <= 1'b0;
      stage      <= '0;
      next_id    <= '0;
      act_id     <= '0;
    end else begin
      if (bus_wr) begin
        if (at(OFS_CTRL))    {ctrl_pause, ctrl_en} <= bus_wdata[1:0];
        if (at(OFS_FLAGS))   stage.cyclic     <= bus_wdata[0];
        if (at(OFS_DST))     stage.dst_addr   <= bus_wdata;
        if (at(OFS_SRC))     stage.src_addr   <= bus_wdata;
        if (at(OFS_DSTRIDE)) stage.dst_stride <= bus_wdata;
        if (at(OFS_SSTRIDE)) stage.src_stride <= bus_wdata;
        if (at(OFS_XLEN))    stage.x_len_m1   <= bus_wdata[LEN_W-1:0];
        if (at(OFS_YLEN))    stage.y_len_m1   <= bus_wdata[LEN_W-1:0];
      end
      if (accept)  next_id <= next_id + ID_W'(1);
      if (q_fired) act_id  <= req_id;
    end
  end

  dreq_queue #(.DEPTH(QDEPTH), .ID_W(ID_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(!ctrl_en), .hold(!ctrl_en || ctrl_pause),
    .push(accept), .push_desc(stage), .push_id(next_id),
    .out_valid(req_valid), .out_ready(req_ready), .out_desc(head), .out_id(req_id),
    .full(q_full), .fired(q_fired), .popped(q_popped), .level(q_level)
  );

  assign req_dst_addr   = head.dst_addr;
  assign req_src_addr   = head.src_addr;
  assign req_dst_stride = head.dst_stride;
  assign req_src_stride = head.src_stride;
  assign req_x_len_m1   = head.x_len_m1;
  assign req_y_len_m1   = head.y_len_m1;
  assign req_cyclic     = head.cyclic;

  dreq_done_map #(.ID_W(ID_W)) u_done (
    .clk(clk), .rst_n(rst_n), .clr_en(accept), .clr_id(next_id),
    .set_en(done_valid), .set_id(done_id), .done_map(done_map)
  );

  dreq_irq #(.N_SRC(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec({done_valid, q_popped}),
    .mask_we(bus_wr && at(OFS_IRQ_MASK)), .pend_we(bus_wr && at(OFS_IRQ_PEND)),
    .wdata(bus_wdata[1:0]), .pending(irq_pend), .mask(irq_mask), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (at(OFS_IRQ_MASK)) rd_mux = 32'(irq_mask);
    if (at(OFS_IRQ_PEND)) rd_mux = 32'(irq_pend);
    if (at(OFS_IRQ_SRC))  rd_mux = 32'(irq_pend & ~irq_mask);
    if (at(OFS_CTRL))     rd_mux = {30'd0, ctrl_pause, ctrl_en};
    if (at(OFS_NEXT_ID))  rd_mux = 32'(next_id);
    if (at(OFS_START))    rd_mux = {31'd0, q_full || !ctrl_en};
    if (at(OFS_FLAGS))    rd_mux = {31'd0, stage.cyclic};
    if (at(OFS_DST))      rd_mux = stage.dst_addr;
    if (at(OFS_SRC))      rd_mux = stage.src_addr;
    if (at(OFS_XLEN))     rd_mux = 32'(stage.x_len_m1);
    if (at(OFS_YLEN))     rd_mux = 32'(stage.y_len_m1);
    if (at(OFS_DSTRIDE))  rd_mux = stage.dst_stride;
    if (at(OFS_SSTRIDE))  rd_mux = stage.src_stride;
    if (at(OFS_DONE_MAP)) rd_mux = 32'(done_map);
    if (at(OFS_ACT_ID))   rd_mux = 32'(act_id);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/dreq_checker.sv
module dreq_checker #(
  parameter int QDEPTH = 4,
  parameter int ID_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [ID_W-1:0]          req_id,
  input logic                     req_cyclic,
  input logic                     done_valid,
  input logic [ID_W-1:0]          done_id,
  input logic                     irq,
  input logic                     en,
  input logic                     pause,
  input logic                     accepted,
  input logic [ID_W-1:0]          nid,
  input logic [$clog2(QDEPTH+1)-1:0] level,
  input logic [1:0]               pending,
  input logic [(1<<ID_W)-1:0]     dmap
);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(QDEPTH+1))'(QDEPTH));

  assert_id_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> nid == $past(nid) + ID_W'(1));

  assert_hold_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> (!en || pause || (req_valid && $stable(req_id))));

  assert_pause_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> !req_valid);

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> level == '0);

  assert_done_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> dmap[$past(done_id)]);

  assert_sot_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_cyclic |=> pending[0]);

  assert_eot_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> pending[1]);

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pending == 2'b00 |-> !irq);

  assert_cyclic_stays_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_cyclic |=>
      (!en || pause || (req_valid && req_id == $past(req_id))));
endmodule

bind dma_req_regs dreq_checker #(.QDEPTH(QDEPTH), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_id(req_id), .req_cyclic(req_cyclic), .done_valid(done_valid),
  .done_id(done_id), .irq(irq), .en(ctrl_en), .pause(ctrl_pause),
  .accepted(accept), .nid(next_id), .level(q_level), .pending(irq_pend),
  .dmap(done_map)
);

// File: tb/test_dma_req_regs.sv
module test_dma_req_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [1:0]  req_id;
  logic [31:0] req_dst_addr, req_src_addr, req_dst_stride, req_src_stride;
  logic [23:0] req_x_len_m1, req_y_len_m1;
  logic        req_cyclic;
  logic        done_valid = 1'b0;
  logic [1:0]  done_id = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_regs i_dma_req_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
    .req_dst_addr(req_dst_addr), .req_src_addr(req_src_addr),
    .req_dst_stride(req_dst_stride), .req_src_stride(req_src_stride),
    .req_x_len_m1(req_x_len_m1), .req_y_len_m1(req_y_len_m1),
    .req_cyclic(req_cyclic), .done_valid(done_valid), .done_id(done_id), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 12'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic handshake();
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
  endtask

  task automatic finish_pulse(input logic [1:0] id);
    @(negedge clk); done_valid = 1'b1; done_id = id;
    @(negedge clk); done_valid = 1'b0;
  endtask

  function automatic logic [31:0] dst_of(input int r, input int k);
    return 32'h1000_0000 + 32'(r * 256 + k * 16);
  endfunction

  localparam int SOFS [8] = '{'h40C, 'h410, 'h414, 'h418, 'h41C, 'h420, 'h424, 'h080};
  localparam logic [31:0] SMSK [8] = '{32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h00FF_FFFF,
                                       32'h00FF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h3};

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 req_valid", {31'd0, req_valid}, 0);
    rdchk("R1 mask", 'h080, 3);
    rdchk("R1 pending", 'h084, 0);
    rdchk("R1 ctrl", 'h400, 0);
    rdchk("R1 next id", 'h404, 0);
    rdchk("R1 done map", 'h428, 0);
    rdchk("R4 busy while disabled", 'h408, 1);

    // R2 staging readback sweep
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++) begin
        logic [31:0] pat;
        pat = (32'h9E37_79B9 * 32'(p + 1)) ^ 32'(SOFS[i] << 8);
        wr(SOFS[i], pat);
        rdchk($sformatf("R2 reg %0h", SOFS[i]), SOFS[i], pat & SMSK[i]);
      end
    end
    wr('h080, 3);
    wr('h40C, 0);

    // R4 start ignored while disabled
    wr('h408, 1);
    rdchk("R4 id unchanged when disabled", 'h404, 0);
    chk("R4 no request when disabled", {31'd0, req_valid}, 0);

    wr('h400, 1);
    rdchk("R4 not busy", 'h408, 0);

    // R3 R4 R5 R9 R13 fill and drain rounds
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 4; k++) begin
        wr('h410, dst_of(r, k));
        wr('h414, 32'h2000_0000 + 32'(r * 256 + k));
        wr('h418, 32'(63 + k + r));
        wr('h41C, 32'(r));
        wr('h420, 32'(k * 4));
        wr('h424, 32'(r * 4));
        wr('h408, 1);
        rdchk("R3 next id", 'h404, 32'((4 * r + k + 1) % 4));
      end
      rdchk("R4 busy when full", 'h408, 1);
      wr('h408, 1);
      rdchk("R4 id unchanged when full", 'h404, 0);
      wr('h084, 3);
      for (int k = 0; k < 4; k++) begin
        chk("R5 valid", {31'd0, req_valid}, 1);
        chk("R5 id", 32'(req_id), 32'(k));
        chk("R5 dst", req_dst_addr, dst_of(r, k));
        chk("R5 src", req_src_addr, 32'h2000_0000 + 32'(r * 256 + k));
        chk("R5 xlen", 32'(req_x_len_m1), 32'(63 + k + r));
        chk("R5 ylen", 32'(req_y_len_m1), 32'(r));
        chk("R5 dstride", req_dst_stride, 32'(k * 4));
        chk("R5 sstride", req_src_stride, 32'(r * 4));
        @(negedge clk);
        chk("R5 held id", 32'(req_id), 32'(k));
        chk("R5 held dst", req_dst_addr, dst_of(r, k));
        handshake();
      end
      chk("R4 ignored start left no entry", {31'd0, req_valid}, 0);
      rdchk("R9 sot pending", 'h084, 1);
      rdchk("R13 active id", 'h42C, 3);
      rdchk("R4 space again", 'h408, 0);
    end

    // R8 R9 done sweep over every ID
    wr('h084, 3);
    for (int id = 0; id < 4; id++) begin
      finish_pulse(2'(id));
      rdchk("R8 done map", 'h428, 32'((1 << (id + 1)) - 1));
      rdchk("R9 eot pending", 'h084, 2);
    end

    // R11 mask sweep with pending = 2
    for (int m = 0; m < 4; m++) begin
      wr('h080, 32'(m));
      chk("R11 irq", {31'd0, irq}, {31'd0, ((2 & ~m) & 3) != 0});
      rdchk("R11 source", 'h088, 32'((2 & ~m) & 3));
    end

    // R10 write-one-to-clear
    wr('h080, 0);
    wr('h084, 1);
    rdchk("R10 zero bit keeps pending", 'h084, 2);
    wr('h084, 2);
    rdchk("R10 one bit clears", 'h084, 0);
    chk("R11 irq low after clear", {31'd0, irq}, 0);

    // R8 reassignment clears the bit
    wr('h408, 1);
    rdchk("R8 reassigned id cleared", 'h428, 32'hE);
    rdchk("R3 id after wrap", 'h404, 1);

    // R6 pause
    wr('h400, 3);
    chk("R6 paused valid", {31'd0, req_valid}, 0);
    @(negedge clk);
    chk("R6 still paused", {31'd0, req_valid}, 0);
    wr('h400, 1);
    chk("R6 resumed valid", {31'd0, req_valid}, 1);
    chk("R6 resumed id", 32'(req_id), 0);

    // R7 flush
    wr('h400, 0);
    wr('h400, 1);
    chk("R7 flushed", {31'd0, req_valid}, 0);
    rdchk("R7 empty", 'h408, 0);

    // R12 repeating entry
    wr('h40C, 1);
    wr('h408, 1);
    wr('h084, 3);
    for (int t = 0; t < 3; t++) begin
      chk("R12 valid", {31'd0, req_valid}, 1);
      chk("R12 id", 32'(req_id), 1);
      chk("R12 flag", {31'd0, req_cyclic}, 1);
      handshake();
    end
    rdchk("R12 no sot", 'h084, 0);
    rdchk("R13 active id cyclic", 'h42C, 1);
    wr('h400, 0);
    wr('h400, 1);
    chk("R12 gone after disable", {31'd0, req_valid}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule